// File: doc/BRIEF.md
# SMBus Configuration Register File for a Clock Generator

This block lets a system management host read and change the settings of a clock generator over a two-wire SMBus link. It holds ten 8-bit configuration registers. Their stored values are driven out in parallel to the clock logic. A few status positions are not stored at all: on a read they return the live level of external strap and stop pins.

The slave runs entirely on the system clock. SCL and SDA pass through a two-flop synchroniser. The block then finds start, repeated start and stop conditions, and bit edges, from the synchronised levels. It answers to the 7-bit address 0x69, which is 0xD2 on the wire for a write and 0xD3 for a read. The top bit of the command byte picks between a single-register access at a given offset and a block access that always begins at register 0. The open-drain SDA driver is represented by an enable output: a 1 pulls the line low.

Top module: `clkgen_smb_regfile`

## Requirements
- R1: During and after reset, `cfgOut` holds the power-up values. Registers 0 to 9 hold, in that order: 0x08, 0x07, 0x7F, 0xC7, 0x3F, 0x40, 0x08, 0x0E, 0x00, 0x00. Register k sits at `cfgOut[8k+7:8k]`.
- R2: An address byte whose upper seven bits are not 0x69 gets no acknowledge. SDA is then left undriven until the next start condition, including during the slots of any later bytes.
- R3: In the command byte, bit 7 = 1 selects a single-register access, with bits 6:0 giving the register offset. Bit 7 = 0 selects a block access starting at register 0.
- R4: A byte write (0xD2, command, data) stores the data. A byte read (0xD2, command, repeated start, 0xD3) returns that register MSB first. A master NACK then ends the read.
- R5: A block write (0xD2, command 0x00, count, data...) acknowledges every byte and writes the data bytes to registers 0, 1, 2 and so on. The count byte does not limit the writes, and a stop after any complete byte keeps the bytes already written.
- R6: A block read (0xD2, command 0x00, repeated start, 0xD3) first returns the register count, 0x0A. It then returns registers 0, 1, 2 and so on while the master acknowledges.
- R7: On a read, register 0 bits 2:0 show the three frequency-select pins and bit 4 shows the CPU stop pin. Register 1 bit 7 shows the multiplier-select pin. Writes to these positions have no effect, and they read as 0 in `cfgOut`.
- R8: On a read, register 0 bit 3 returns its stored bit ANDed with the PCI stop pin. `cfgOut` carries the stored bit alone.
- R9: Register 6 always reads 0x08, and writes to it change nothing.
- R10: Offsets 10 and above read as 0x00. Writes to them are acknowledged and discarded.
- R11: A stop or start condition releases SDA. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SMBus clock line level |
| sdaIn | input | 1 | SMBus data line level |
| sdaOe | output | 1 | Pulls SDA low when 1 |
| selPins | input | 3 | Frequency-select strap pins |
| cpuStopPinN | input | 1 | CPU clock stop pin, active low |
| pciStopPinN | input | 1 | PCI clock stop pin, active low |
| multPin | input | 1 | Output current multiplier select pin |
| cfgOut | output | NUM_REGS*8 | Stored register contents, register k at bits 8k+7:8k |

## Verification
The assertions assume that the system clock runs much faster than SCL, so that every SCL level lasts longer than the synchroniser and edge-detect latency. They also assume that the master moves SDA only while SCL is low, except when it makes a start or stop. The bench keeps to this by holding every quarter of an SCL period for six system clocks. It changes its own SDA drive only in the low quarter, or in the high quarter for start and stop conditions. The strap and stop pins are changed only between transactions, so each read-back value is settled before the byte that carries it is loaded.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam logic [6:0] SLAVE_ADDR    = 7'h69;
  localparam int         REG_STATUS    = 0;
  localparam int         REG_CPUCTL    = 1;
  localparam int         REG_SIGNATURE = 6;

  typedef enum logic [2:0] {
    P_IDLE,
    P_ADDR,
    P_CMD,
    P_COUNT,
    P_WDATA,
    P_RDATA
  } smbPhase_t;

  // strobes from the protocol control to the register datapath
  typedef struct packed {
    logic       wrEn;
    logic [6:0] addr;
    logic [7:0] wrData;
  } regStrobe_t;

  function automatic logic [7:0] regDefault(input int idx);
    case (idx)
      0:       return 8'h08;
      1:       return 8'h07;
      2:       return 8'h7F;
      3:       return 8'hC7;
      4:       return 8'h3F;
      5:       return 8'h40;
      6:       return 8'h08;
      7:       return 8'h0E;
      default: return 8'h00;
    endcase
  endfunction

  // 1 = bit is host writable
  function automatic logic [7:0] regWrMask(input int idx);
    case (idx)
      REG_STATUS:    return 8'hE8;
      REG_CPUCTL:    return 8'h7F;
      REG_SIGNATURE: return 8'h00;
      default:       return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic              sclPrev;
  logic              sdaPrev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[STAGES-1];
  assign sdaS = sdaPipe[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  // SDA moving while SCL stays high marks a bus condition
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_cfg_pkg::*;
#(
  parameter int NUM_REGS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaS,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic [7:0] rdData,
  output logic       sdaOe,
  output regStrobe_t strobe
);

  localparam logic [3:0] BYTE_BITS = 4'd8;
  localparam logic [6:0] PTR_MAX   = '1;
  localparam logic [7:0] COUNT_VAL = 8'(NUM_REGS);

  smbPhase_t  phase;
  smbPhase_t  nextPh;
  logic [3:0] bitCnt;
  logic       inAck;
  logic [7:0] rxByte;
  logic [7:0] txByte;
  logic [6:0] ptr;
  logic       rdArmed;
  logic       sendCount;
  logic       mAck;
  logic [7:0] loadByte;

  assign loadByte = sendCount ? COUNT_VAL : rdData;

  assign strobe.addr   = ptr;
  assign strobe.wrData = rxByte;
  assign strobe.wrEn   = (phase == P_WDATA) && sclFall && !inAck && (bitCnt == BYTE_BITS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= P_IDLE;
      nextPh    <= P_IDLE;
      bitCnt    <= '0;
      inAck     <= 1'b0;
      rxByte    <= '0;
      txByte    <= '0;
      ptr       <= '0;
      rdArmed   <= 1'b0;
      sendCount <= 1'b0;
      mAck      <= 1'b0;
      sdaOe     <= 1'b0;
    end else if (startEv) begin
      phase  <= P_ADDR;
      bitCnt <= '0;
      inAck  <= 1'b0;
      sdaOe  <= 1'b0;
    end else if (stopEv) begin
      phase   <= P_IDLE;
      bitCnt  <= '0;
      inAck   <= 1'b0;
      sdaOe   <= 1'b0;
      rdArmed <= 1'b0;
    end else if (phase == P_RDATA) begin
      if (!inAck) begin
        if (sclRise && bitCnt != BYTE_BITS) begin
          bitCnt <= bitCnt + 4'd1;
        end else if (sclFall && bitCnt == BYTE_BITS) begin
          bitCnt <= '0;
          inAck  <= 1'b1;
          sdaOe  <= 1'b0;
        end else if (sclFall && bitCnt != 4'd0) begin
          txByte <= {txByte[6:0], 1'b0};
          sdaOe  <= ~txByte[6];
        end
      end else begin
        if (sclRise) begin
          mAck <= ~sdaS;
        end else if (sclFall) begin
          inAck <= 1'b0;
          if (mAck) begin
            txByte <= loadByte;
            sdaOe  <= ~loadByte[7];
            if (sendCount) sendCount <= 1'b0;
            else if (ptr != PTR_MAX) ptr <= ptr + 7'd1;
          end else begin
            phase <= P_IDLE;
          end
        end
      end
    end else if (phase != P_IDLE) begin
      if (!inAck) begin
        if (sclRise && bitCnt != BYTE_BITS) begin
          rxByte <= {rxByte[6:0], sdaS};
          bitCnt <= bitCnt + 4'd1;
        end else if (sclFall && bitCnt == BYTE_BITS) begin
          bitCnt <= '0;
          case (phase)
            P_ADDR: begin
              if (rxByte[7:1] == SLAVE_ADDR && (!rxByte[0] || rdArmed)) begin
                inAck   <= 1'b1;
                sdaOe   <= 1'b1;
                rdArmed <= 1'b0;
                nextPh  <= rxByte[0] ? P_RDATA : P_CMD;
              end else begin
                phase <= P_IDLE;
              end
            end
            P_CMD: begin
              inAck     <= 1'b1;
              sdaOe     <= 1'b1;
              rdArmed   <= 1'b1;
              sendCount <= ~rxByte[7];
              ptr       <= rxByte[7] ? rxByte[6:0] : 7'd0;
              nextPh    <= rxByte[7] ? P_WDATA : P_COUNT;
            end
            P_COUNT: begin
              inAck   <= 1'b1;
              sdaOe   <= 1'b1;
              rdArmed <= 1'b0;
              nextPh  <= P_WDATA;
            end
            default: begin
              inAck   <= 1'b1;
              sdaOe   <= 1'b1;
              rdArmed <= 1'b0;
              nextPh  <= P_WDATA;
              if (ptr != PTR_MAX) ptr <= ptr + 7'd1;
            end
          endcase
        end
      end else if (sclFall) begin
        inAck <= 1'b0;
        phase <= nextPh;
        if (nextPh == P_RDATA) begin
          txByte <= loadByte;
          sdaOe  <= ~loadByte[7];
          if (sendCount) sendCount <= 1'b0;
          else if (ptr != PTR_MAX) ptr <= ptr + 7'd1;
        end else begin
          sdaOe <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_cfg_pkg::*;
#(
  parameter int NUM_REGS = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic [2:0]            selPins,
  input  logic                  cpuStopPinN,
  input  logic                  pciStopPinN,
  input  logic                  multPin,
  output logic [7:0]            rdData,
  output logic [NUM_REGS*8-1:0] cfgOut
);

  logic [7:0] viewQ [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [7:0] DEF  = regDefault(g);
      localparam logic [7:0] MASK = regWrMask(g);
      logic [7:0] q;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= DEF;
        else if (strobe.wrEn && strobe.addr == 7'(g))
          q <= (strobe.wrData & MASK) | (q & ~MASK);
      end

      assign cfgOut[g*8 +: 8] = q;

      if (g == REG_STATUS) begin : g_status
        assign viewQ[g] = {q[7:5], cpuStopPinN, q[3] & pciStopPinN, selPins};
      end else if (g == REG_CPUCTL) begin : g_cpuctl
        assign viewQ[g] = {multPin, q[6:0]};
      end else begin : g_plain
        assign viewQ[g] = q;
      end
    end
  endgenerate

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strobe.addr == 7'(i)) rdData = viewQ[i];
    end
  end

endmodule

// File: rtl/clkgen_smb_regfile.sv
module clkgen_smb_regfile
  import smb_cfg_pkg::*;
#(
  parameter int NUM_REGS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic [2:0]            selPins,
  input  logic                  cpuStopPinN,
  input  logic                  pciStopPinN,
  input  logic                  multPin,
  output logic [NUM_REGS*8-1:0] cfgOut
);

  logic       sclSync;
  logic       sdaSync;
  logic       sclRise;
  logic       sclFall;
  logic       startEv;
  logic       stopEv;
  logic [7:0] rdData;
  regStrobe_t regStb;

  smb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclSync), .sdaS(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  smb_ctrl #(.NUM_REGS(NUM_REGS)) i_ctrl (
    .clk(clk), .rstN(rstN), .sdaS(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .rdData(rdData),
    .sdaOe(sdaOe), .strobe(regStb)
  );

  smb_regbank #(.NUM_REGS(NUM_REGS)) i_bank (
    .clk(clk), .rstN(rstN), .strobe(regStb), .selPins(selPins),
    .cpuStopPinN(cpuStopPinN), .pciStopPinN(pciStopPinN), .multPin(multPin),
    .rdData(rdData), .cfgOut(cfgOut)
  );

endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker #(
  parameter int NUM_REGS = 10
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclS,
  input logic                  startEv,
  input logic                  stopEv,
  input logic                  sdaOe,
  input logic                  wrEn,
  input logic [NUM_REGS*8-1:0] cfgOut
);

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaOe)); // R11

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe); // R11

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> !sdaOe); // R11

  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> sdaOe); // R5

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> $stable(cfgOut)); // R4

endmodule

bind clkgen_smb_regfile smb_cfg_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclSync), .startEv(startEv), .stopEv(stopEv),
  .sdaOe(sdaOe), .wrEn(regStb.wrEn), .cfgOut(cfgOut)
);

// File: tb/test_clkgen_smb_regfile.sv
module test_clkgen_smb_regfile;

  localparam int NUM_REGS = 10;
  localparam int QTR      = 6;
  localparam int NVEC     = 8;
  // {offset, write data, expected read-back}
  localparam logic [22:0] VECS [NVEC] = '{
    {7'd2,  8'h55, 8'h55},
    {7'd3,  8'hA3, 8'hA3},
    {7'd0,  8'hFF, 8'hFD},
    {7'd1,  8'hFF, 8'h7F},
    {7'd6,  8'hFF, 8'h08},
    {7'd12, 8'h77, 8'h00},
    {7'd9,  8'h81, 8'h81},
    {7'd0,  8'h00, 8'h15}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaBus;
  logic sdaOe;
  logic [2:0] selPins = 3'b101;
  logic cpuStopPinN = 1'b1;
  logic pciStopPinN = 1'b1;
  logic multPin = 1'b0;
  logic [NUM_REGS*8-1:0] cfgOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  assign sdaBus = mSda & ~sdaOe;

  clkgen_smb_regfile i_clkgen_smb_regfile (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .selPins(selPins), .cpuStopPinN(cpuStopPinN), .pciStopPinN(pciStopPinN),
    .multPin(multPin), .cfgOut(cfgOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic quarter();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; quarter();
    mScl = 1'b1; quarter();
    mSda = 1'b0; quarter();
    mScl = 1'b0; quarter();
  endtask

  task automatic busStop();
    mSda = 1'b0; quarter();
    mScl = 1'b1; quarter();
    mSda = 1'b1; quarter();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; quarter();
      mScl = 1'b1; quarter(); quarter();
      mScl = 1'b0; quarter();
    end
    mSda = 1'b1; quarter();
    mScl = 1'b1; quarter();
    acked = (sdaBus == 1'b0);
    quarter();
    mScl = 1'b0; quarter();
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      quarter();
      mScl = 1'b1; quarter();
      b[i] = sdaBus;
      quarter();
      mScl = 1'b0;
    end
    mSda = giveAck ? 1'b0 : 1'b1; quarter();
    mScl = 1'b1; quarter(); quarter();
    mScl = 1'b0; quarter();
    mSda = 1'b1;
  endtask

  task automatic byteWrite(input logic [6:0] off, input logic [7:0] d, output bit allAck);
    bit a0, a1, a2;
    busStart();
    sendByte(8'hD2, a0);
    sendByte({1'b1, off}, a1);
    sendByte(d, a2);
    busStop();
    quarter();
    allAck = a0 & a1 & a2;
  endtask

  task automatic byteRead(input logic [6:0] off, output logic [7:0] d, output bit allAck);
    bit a0, a1, a2;
    busStart();
    sendByte(8'hD2, a0);
    sendByte({1'b1, off}, a1);
    busStart();
    sendByte(8'hD3, a2);
    recvByte(1'b0, d);
    busStop();
    quarter();
    allAck = a0 & a1 & a2;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    logic [7:0] rdB [4];
    bit ok;
    bit acks [6];
    repeat (5) @(negedge clk);
    chk(cfgOut == 80'h0000_0E08_403F_C77F_0708, "R1 defaults during reset", cfgOut, 80'h0000_0E08_403F_C77F_0708);
    chk(sdaOe == 1'b0, "R11 SDA released in reset", sdaOe, 0);
    rstN = 1'b1;
    quarter();
    chk(cfgOut == 80'h0000_0E08_403F_C77F_0708, "R1 defaults after reset", cfgOut, 80'h0000_0E08_403F_C77F_0708);

    // reg0 default read-back: stored 0x08, pins sel=101, cpu stop=1, pci stop=1
    byteRead(7'd0, rd, ok);
    chk(ok, "R4 byte read acked", ok, 1);
    chk(rd == 8'h1D, "R7 R8 reg0 read after reset", rd, 8'h1D);

    for (int i = 0; i < NVEC; i++) begin
      logic [6:0] off;
      logic [7:0] wd;
      logic [7:0] ex;
      {off, wd, ex} = VECS[i];
      byteWrite(off, wd, ok);
      chk(ok, "R4 byte write acked", ok, 1);
      byteRead(off, rd, ok);
      chk(ok && rd == ex, "R3 R4 byte access at offset", rd, ex);
    end
    chk(cfgOut[7:0] == 8'h00, "R7 reg0 read-only bits zero in cfgOut", cfgOut[7:0], 8'h00);
    chk(cfgOut[15:8] == 8'h7F, "R7 reg1 pin bit not stored", cfgOut[15:8], 8'h7F);
    chk(cfgOut[55:48] == 8'h08, "R9 signature unchanged", cfgOut[55:48], 8'h08);
    chk(cfgOut == 80'h8100_0E08_403F_A355_7F00, "R10 discarded write touched nothing", cfgOut, 80'h8100_0E08_403F_A355_7F00);
    byteRead(7'd100, rd, ok);
    chk(ok && rd == 8'h00, "R10 far offset reads zero", rd, 8'h00);

    // PCI stop AND
    byteWrite(7'd0, 8'h08, ok);
    pciStopPinN = 1'b0;
    byteRead(7'd0, rd, ok);
    chk(rd == 8'h15, "R8 pci stop pin low masks bit3", rd, 8'h15);
    chk(cfgOut[3] == 1'b1, "R8 stored bit kept in cfgOut", cfgOut[3], 1);
    pciStopPinN = 1'b1;
    byteRead(7'd0, rd, ok);
    chk(rd == 8'h1D, "R8 pci stop pin high passes bit3", rd, 8'h1D);

    // live pins
    selPins = 3'b010; cpuStopPinN = 1'b0; multPin = 1'b1;
    byteRead(7'd0, rd, ok);
    chk(rd == 8'h0A, "R7 reg0 shows live pins", rd, 8'h0A);
    byteRead(7'd1, rd, ok);
    chk(rd == 8'hFF, "R7 reg1 shows multiplier pin", rd, 8'hFF);

    // block write, count 3, stop after third data byte
    busStart();
    sendByte(8'hD2, acks[0]);
    sendByte(8'h00, acks[1]);
    sendByte(8'h03, acks[2]);
    sendByte(8'hA0, acks[3]);
    sendByte(8'h25, acks[4]);
    sendByte(8'h9C, acks[5]);
    busStop();
    quarter();
    chk(acks[0] & acks[1] & acks[2] & acks[3] & acks[4] & acks[5], "R5 block write bytes acked", 0, 1);
    chk(cfgOut[23:0] == 24'h9C25A0, "R5 block write regs 0..2", cfgOut[23:0], 24'h9C25A0);
    chk(cfgOut[31:24] == 8'hA3, "R5 reg3 untouched after stop", cfgOut[31:24], 8'hA3);
    chk(sdaOe == 1'b0, "R11 SDA released after stop", sdaOe, 0);

    // block read: count, then reg0 (0xA2), reg1 (0xA5), reg2 (0x9C)
    busStart();
    sendByte(8'hD2, acks[0]);
    sendByte(8'h00, acks[1]);
    busStart();
    sendByte(8'hD3, acks[2]);
    recvByte(1'b1, rdB[0]);
    recvByte(1'b1, rdB[1]);
    recvByte(1'b1, rdB[2]);
    recvByte(1'b0, rdB[3]);
    busStop();
    quarter();
    chk(acks[0] & acks[1] & acks[2], "R6 block read header acked", 0, 1);
    chk(rdB[0] == 8'h0A, "R6 block read count", rdB[0], 8'h0A);
    chk({rdB[1], rdB[2], rdB[3]} == 24'hA2A59C, "R6 block read data", {rdB[1], rdB[2], rdB[3]}, 24'hA2A59C);
    chk(sdaOe == 1'b0, "R11 SDA released after read stop", sdaOe, 0);

    // wrong address 0x50
    busStart();
    sendByte(8'hA0, acks[0]);
    chk(!acks[0], "R2 foreign address not acked", acks[0], 0);
    sendByte(8'h80, acks[1]);
    chk(!acks[1], "R2 later byte not acked", acks[1], 0);
    chk(sdaOe == 1'b0, "R2 SDA undriven after mismatch", sdaOe, 0);
    busStop();
    quarter();
    byteRead(7'd2, rd, ok);
    chk(ok && rd == 8'h9C, "R2 slave answers after mismatch", rd, 8'h9C);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule